// File: doc/BRIEF.md
# CAN Overload Frame Sequencer

This block works at bit level inside a CAN protocol engine. It takes over the bus right after a frame's end-of-frame field or an error delimiter. It then runs the interframe period. During that period it decides whether an overload frame has to be sent. When one is needed, it drives a six-bit dominant flag onto the transmit line. After the flag it releases the line and tracks the recessive delimiter on the sampled receive bit.

The rest of the controller gives it four things. The first is a strobe at each bit's sample point. The second is the sampled receive bit. The third is a one-strobe marker for the final end-of-frame bit or the final error-delimiter bit. The fourth is a local request meaning "not ready to receive". In return the block produces the transmit bit, a busy flag that covers the whole overload frame, and a one-cycle pulse when intermission ends. After that pulse the protocol engine may accept a start of frame.

The sequencer allows for flags from several nodes that overlap. After its own six dominant bits it waits for the bus to go recessive before it starts counting the delimiter. A dominant bit on the last delimiter bit chains a new overload frame straight away.

Top module: `can_ovld_seq`

## Requirements
- R1: Once reset ends, `tx_bit` is 1 (recessive), `busy` is 0 and `ifs_done` is 0.
- R2: An overload frame starts with `tx_bit` at 0 (dominant) from the bit right after the triggering strobe. `tx_bit` stays 0 for exactly six bit strobes and returns to 1 after the sixth.
- R3: After the flag, `tx_bit` stays 1 and `busy` stays 1 for as long as the sampled bus reads 0, for any number of extra dominant bits. The first recessive bit sampled counts as delimiter bit 1.
- R4: The delimiter is eight recessive bits in total. When a 1 is sampled at the eighth bit, `busy` drops and intermission begins.
- R5: An overload frame is triggered by a 0 sampled at any of these points: with `eof_last`, with `errdelim_last`, or at intermission bit 1 or bit 2.
- R6: A 0 sampled at the eighth bit of the block's own overload delimiter starts a new flag on the very next bit.
- R7: Intermission is three bit strobes. `ifs_done` pulses for one clock after the third strobe. A 0 at that third bit also ends intermission and does not start an overload frame.
- R8: `rx_not_ready` is acted on only at intermission bit 1, where it starts an overload frame. At intermission bit 2 it has no effect.
- R9: No more than MAX_LOCAL (2) locally requested overload frames can run back to back. The count resets when an intermission completes.
- R10: State and outputs change only on `bit_stb`. `tx_bit` is 0 only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-clock strobe at each bit's sample point |
| rx_bit | input | 1 | Sampled bus level, 0 dominant, 1 recessive |
| eof_last | input | 1 | Marks that the strobed bit is the final end-of-frame bit |
| errdelim_last | input | 1 | Marks that the strobed bit is the final error-delimiter bit |
| rx_not_ready | input | 1 | Local request to delay the next frame |
| tx_bit | output | 1 | Transmit level, 0 dominant, 1 recessive |
| busy | output | 1 | An overload frame (flag, wait or delimiter) is in progress |
| ifs_done | output | 1 | One-clock pulse when intermission completes |

## Verification
The following invariants are checked every cycle by the embedded assertions:
- `tx_bit` is never dominant while the block is not busy.
- Outputs hold steady between strobes.
- The flag and delimiter counters stay inside their bounds.
- `ifs_done` appears only on a strobe and never during an overload frame.
- The local-request count never goes above its limit.

Other behaviours need the bench scenarios. These are the exact trigger positions, the six-bit flag length, waiting through zero to six overlapping foreign flag bits, the eight-bit delimiter, back-to-back chaining, and the rules for when the local request is counted and cleared. The bench sweeps every trigger point against every extra-dominant length.

// File: rtl/can_ovld_pkg.sv
package can_ovld_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_INTERM  = 3'd1,
      ST_FLAG    = 3'd2,
      ST_WAITREC = 3'd3,
      ST_DELIM   = 3'd4
   } ovl_state_e;
endpackage

// File: rtl/ovl_bitcnt.sv
// Bit-position counter: loaded on state entry, advanced on each strobe.
module ovl_bitcnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic          inc,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (ld)  cnt <= ld_val;
      else if (inc) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ovl_local_limit.sv
// Counts locally requested overload frames since the last completed intermission.
module ovl_local_limit #(
   parameter int MAX_LOCAL    = 2,
   parameter bit LOCAL_REQ_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic clr,
   output logic ok
);
   localparam int LW = $clog2(MAX_LOCAL + 1);

   if (LOCAL_REQ_EN) begin : g_limit
      logic [LW-1:0] used_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     used_q <= '0;
         else if (clr)   used_q <= '0;
         else if (take)  used_q <= used_q + 1'b1;
      end
      assign ok = (used_q < LW'(MAX_LOCAL));

      assert_local_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
         used_q <= LW'(MAX_LOCAL));
   end else begin : g_nolimit
      logic unused_in;
      assign unused_in = ^{clk, rst_n, take, clr};
      assign ok = 1'b0;
   end
endmodule

// File: rtl/ovl_trigger.sv
// Decides, at a strobe, whether the current bit position starts an overload frame.
module ovl_trigger
   import can_ovld_pkg::*;
#(
   parameter int CW         = 4,
   parameter int DELIM_BITS = 8
) (
   input  ovl_state_e    state,
   input  logic [CW-1:0] cnt,
   input  logic          bit_stb,
   input  logic          rx_bit,
   input  logic          eof_last,
   input  logic          errdelim_last,
   input  logic          rx_not_ready,
   input  logic          local_ok,
   output logic          start_ovl,
   output logic          local_take
);
   logic dom, at_ifs1, at_ifs2, at_dlast, remote_hit, local_hit;

   always_comb begin
      dom        = ~rx_bit;
      at_ifs1    = (state == ST_INTERM) && (cnt == CW'(0));
      at_ifs2    = (state == ST_INTERM) && (cnt == CW'(1));
      at_dlast   = (state == ST_DELIM)  && (cnt == CW'(DELIM_BITS - 1));
      remote_hit = dom && (((state == ST_IDLE) && (eof_last || errdelim_last))
                           || at_ifs1 || at_ifs2 || at_dlast);
      local_hit  = at_ifs1 && rx_bit && rx_not_ready && local_ok;
      start_ovl  = bit_stb && (remote_hit || local_hit);
      local_take = bit_stb && local_hit;
   end
endmodule

// File: rtl/can_ovld_seq.sv
module can_ovld_seq
   import can_ovld_pkg::*;
#(
   parameter int FLAG_BITS    = 6,
   parameter int DELIM_BITS   = 8,
   parameter int IFS_BITS     = 3,
   parameter int MAX_LOCAL    = 2,
   parameter bit LOCAL_REQ_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic rx_bit,
   input  logic eof_last,
   input  logic errdelim_last,
   input  logic rx_not_ready,
   output logic tx_bit,
   output logic busy,
   output logic ifs_done
);
   localparam int MAXB = (FLAG_BITS > DELIM_BITS)
                         ? ((FLAG_BITS > IFS_BITS) ? FLAG_BITS : IFS_BITS)
                         : ((DELIM_BITS > IFS_BITS) ? DELIM_BITS : IFS_BITS);
   localparam int CW = $clog2(MAXB + 1);

   if (FLAG_BITS < 1) begin : g_bad_flag
      $error("FLAG_BITS must be at least 1");
   end
   if (DELIM_BITS < 2) begin : g_bad_delim
      $error("DELIM_BITS must be at least 2");
   end
   if (IFS_BITS < 3) begin : g_bad_ifs
      $error("IFS_BITS must be at least 3");
   end
   if (MAX_LOCAL < 1) begin : g_bad_local
      $error("MAX_LOCAL must be at least 1");
   end

   ovl_state_e    state_q, state_d;
   logic [CW-1:0] cnt;
   logic [CW-1:0] ld_val;
   logic          ld, inc, done_d;
   logic          start_ovl, local_take, local_ok;
   logic          tx_q, busy_q, done_q;

   ovl_bitcnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .inc(inc), .cnt(cnt)
   );

   ovl_trigger #(.CW(CW), .DELIM_BITS(DELIM_BITS)) u_trig (
      .state(state_q), .cnt(cnt), .bit_stb(bit_stb), .rx_bit(rx_bit),
      .eof_last(eof_last), .errdelim_last(errdelim_last),
      .rx_not_ready(rx_not_ready), .local_ok(local_ok),
      .start_ovl(start_ovl), .local_take(local_take)
   );

   ovl_local_limit #(.MAX_LOCAL(MAX_LOCAL), .LOCAL_REQ_EN(LOCAL_REQ_EN)) u_lim (
      .clk(clk), .rst_n(rst_n), .take(local_take), .clr(done_d), .ok(local_ok)
   );

   always_comb begin
      state_d = state_q;
      ld      = 1'b0;
      ld_val  = '0;
      inc     = 1'b0;
      done_d  = 1'b0;
      if (start_ovl) begin
         state_d = ST_FLAG;
         ld      = 1'b1;
      end else if (bit_stb) begin
         unique case (state_q)
            ST_IDLE: begin
               if (eof_last || errdelim_last) begin
                  state_d = ST_INTERM;
                  ld      = 1'b1;
               end
            end
            ST_INTERM: begin
               if (cnt == CW'(IFS_BITS - 1)) begin
                  state_d = ST_IDLE;
                  done_d  = 1'b1;
               end else begin
                  inc = 1'b1;
               end
            end
            ST_FLAG: begin
               if (cnt == CW'(FLAG_BITS - 1)) state_d = ST_WAITREC;
               else                           inc     = 1'b1;
            end
            ST_WAITREC: begin
               if (rx_bit) begin
                  state_d = ST_DELIM;
                  ld      = 1'b1;
                  ld_val  = CW'(1);
               end
            end
            ST_DELIM: begin
               if (cnt == CW'(DELIM_BITS - 1)) begin
                  state_d = ST_INTERM;
                  ld      = 1'b1;
               end else begin
                  inc = 1'b1;
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tx_q    <= 1'b1;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         tx_q    <= (state_d != ST_FLAG);
         busy_q  <= (state_d == ST_FLAG) || (state_d == ST_WAITREC) || (state_d == ST_DELIM);
         done_q  <= done_d;
      end
   end

   assign tx_bit   = tx_q;
   assign busy     = busy_q;
   assign ifs_done = done_q;

   assert_tx_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx_bit);
   assert_hold_between_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> ($stable(tx_bit) && $stable(busy)));
   assert_flag_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FLAG) |-> (cnt <= CW'(FLAG_BITS - 1)));
   assert_delim_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DELIM) |-> ((cnt >= CW'(1)) && (cnt <= CW'(DELIM_BITS - 1))));
   assert_done_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ifs_done |-> ($past(bit_stb) && !busy));
endmodule

// File: tb/can_ovld_seq_test.sv
module can_ovld_seq_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_stb = 1'b0, rx_bit = 1'b1, eof_last = 1'b0, errdelim_last = 1'b0;
   logic rx_not_ready = 1'b0;
   logic tx_bit, busy, ifs_done;
   int   n_chk = 0, n_bad = 0;
   bit   finished = 1'b0;

   always #5 clk = ~clk;

   can_ovld_seq uut (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
      .eof_last(eof_last), .errdelim_last(errdelim_last),
      .rx_not_ready(rx_not_ready), .tx_bit(tx_bit), .busy(busy), .ifs_done(ifs_done)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // One bit time: inputs set at a falling edge, strobe for one clock, outputs sampled at the next falling edge.
   task automatic bit_t(input logic rx, input logic eof, input logic ed, input logic nr);
      @(negedge clk);
      rx_bit = rx; eof_last = eof; errdelim_last = ed; rx_not_ready = nr; bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0; eof_last = 1'b0; errdelim_last = 1'b0; rx_not_ready = 1'b0;
   endtask

   // Called right after the trigger strobe; extra = foreign dominant bits after own flag.
   task automatic ovl_body(input int extra, input logic last_rx);
      chk("R2 flag starts", tx_bit, 1'b0);
      chk("R2 busy at flag", busy, 1'b1);
      for (int i = 1; i < 6; i++) begin
         bit_t(1'b0, 1'b0, 1'b0, 1'b0);
         chk("R2 flag held", tx_bit, 1'b0);
      end
      bit_t(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R2 flag ends after six", tx_bit, 1'b1);
      for (int j = 0; j < extra; j++) begin
         bit_t(1'b0, 1'b0, 1'b0, 1'b0);
         chk("R3 waits recessive tx", tx_bit, 1'b1);
         chk("R3 waits recessive busy", busy, 1'b1);
      end
      for (int k = 1; k < 8; k++) begin
         bit_t(1'b1, 1'b0, 1'b0, 1'b0);
         chk("R4 delimiter busy", busy, 1'b1);
         chk("R4 delimiter tx", tx_bit, 1'b1);
      end
      bit_t(last_rx, 1'b0, 1'b0, 1'b0);
      if (last_rx) begin
         chk("R4 delimiter ends", busy, 1'b0);
         chk("R4 delimiter ends tx", tx_bit, 1'b1);
      end else begin
         chk("R6 chained flag", tx_bit, 1'b0);
      end
   endtask

   task automatic finish_ifs();
      bit_t(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R7 ifs bit1 no done", ifs_done, 1'b0);
      bit_t(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R7 ifs bit2 no done", ifs_done, 1'b0);
      bit_t(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R7 ifs done pulse", ifs_done, 1'b1);
      chk("R7 idle after ifs", busy, 1'b0);
      @(negedge clk);
      chk("R7 pulse one clock", ifs_done, 1'b0);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 tx after reset", tx_bit, 1'b1);
      chk("R1 busy after reset", busy, 1'b0);
      chk("R1 done after reset", ifs_done, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // Plain intermission after a frame
      bit_t(1'b1, 1'b1, 1'b0, 1'b0);
      chk("R7 no overload", tx_bit, 1'b1);
      finish_ifs();

      // Sweep trigger point x foreign dominant overlap 0..6 (R5, R3)
      for (int pos = 0; pos < 4; pos++) begin
         for (int e = 0; e <= 6; e++) begin
            case (pos)
               0: bit_t(1'b0, 1'b1, 1'b0, 1'b0);
               1: begin bit_t(1'b1, 1'b1, 1'b0, 1'b0); bit_t(1'b0, 1'b0, 1'b0, 1'b0); end
               2: begin
                  bit_t(1'b1, 1'b1, 1'b0, 1'b0);
                  bit_t(1'b1, 1'b0, 1'b0, 1'b0);
                  bit_t(1'b0, 1'b0, 1'b0, 1'b0);
               end
               default: bit_t(1'b0, 1'b0, 1'b1, 1'b0);
            endcase
            chk("R5 trigger point", tx_bit, 1'b0);
            ovl_body(e, 1'b1);
            finish_ifs();
         end
      end

      // Dominant at third intermission bit is a start of frame (R7)
      bit_t(1'b1, 1'b0, 1'b1, 1'b0);
      bit_t(1'b1, 1'b0, 1'b0, 1'b0);
      bit_t(1'b1, 1'b0, 1'b0, 1'b0);
      bit_t(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R7 sof at bit3 no flag", tx_bit, 1'b1);
      chk("R7 sof at bit3 done", ifs_done, 1'b1);
      chk("R7 sof at bit3 not busy", busy, 1'b0);

      // Chained overload via dominant at delimiter bit 8 (R6); strobe gating (R10)
      bit_t(1'b0, 1'b1, 1'b0, 1'b0);
      rx_bit = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 no change without strobe tx", tx_bit, 1'b0);
      chk("R10 no change without strobe busy", busy, 1'b1);
      ovl_body(2, 1'b0);
      ovl_body(0, 1'b1);
      finish_ifs();

      // Local request rules (R8, R9)
      bit_t(1'b1, 1'b1, 1'b0, 1'b0);
      bit_t(1'b1, 1'b0, 1'b0, 1'b0);
      bit_t(1'b1, 1'b0, 1'b0, 1'b1);
      chk("R8 request at bit2 ignored", tx_bit, 1'b1);
      chk("R8 request at bit2 not busy", busy, 1'b0);
      bit_t(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R8 ifs completes", ifs_done, 1'b1);

      bit_t(1'b1, 1'b1, 1'b0, 1'b0);
      bit_t(1'b1, 1'b0, 1'b0, 1'b1);
      chk("R8 request at bit1 honoured", tx_bit, 1'b0);
      ovl_body(0, 1'b1);
      bit_t(1'b1, 1'b0, 1'b0, 1'b1);
      chk("R9 second local allowed", tx_bit, 1'b0);
      ovl_body(1, 1'b1);
      bit_t(1'b1, 1'b0, 1'b0, 1'b1);
      chk("R9 third local refused", tx_bit, 1'b1);
      chk("R9 third local not busy", busy, 1'b0);
      bit_t(1'b1, 1'b0, 1'b0, 1'b0);
      bit_t(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R9 ifs completes after refusal", ifs_done, 1'b1);

      bit_t(1'b1, 1'b1, 1'b0, 1'b0);
      bit_t(1'b1, 1'b0, 1'b0, 1'b1);
      chk("R9 count cleared by ifs", tx_bit, 1'b0);
      ovl_body(0, 1'b1);
      finish_ifs();

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule